// File: doc/BRIEF.md
# SMBus Register Slave for a Four-Way Signal Router

This block is a synchronous SMBus target for a small 4-output, 4-input routing switch. A fast system clock oversamples the serial clock and data lines. The block finds START and STOP conditions and matches the 7-bit target address. It accepts single-byte register writes and random-address single-byte reads. It pulls the data line low through an open-drain enable for acknowledge bits and for read data.

Three registers are mapped. The route register at 0x00 holds one 2-bit input select per output and drives the switch. The control register at 0x03 holds per-output enables, an input-monitor enable and a soft power-up bit. The read-only link register at 0x04 shows the external per-input signal-presence flags.

A change in either direction on the bus-mode enable input returns the registers to their defaults. While that enable is low, the block stays off the bus. If the serial clock is held low for too long, the block drops back to idle.

Top module: `smb_reg_slave`

## Requirements
- R1: The target address is `101` in bits 6..4 followed by `strap_addr[3:0]` in bits 3..0, sent MSB first with the R/W bit last. Any other address gets no acknowledge. After such an address, every byte is ignored and left unacknowledged until the next START.
- R2: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. The block only starts pulling SDA low while SCL is low.
- R3: After each matched address byte, register-address byte and write-data byte, the block pulls SDA low for the ninth clock (ACK = 0). This happens even when the write itself has no effect.
- R4: A write (START, address+0, register address, data, STOP) stores the data byte in the addressed register. Register outputs change only on such a write or on a mode toggle.
- R5: A read (START, address+0, register address, repeated START, address+1) returns the addressed register MSB first on the following 8 clocks. A host NACK ends the transfer.
- R6: Register 0x00 resets to 0x00 and is read/write. Bits [2k+1:2k] of `route_cfg` select the input for output k, for k = 0..3.
- R7: Register 0x03 resets to 0x0F and all 8 bits are writable and read back. Bits [3:0] are output enables, bit 6 is the input-monitor enable and bit 7 is soft power-up.
- R8: Register 0x04 reads as `{4'b0000, link_ok[3:0]}`, where a 1 means a valid signal is present. A write to it is acknowledged but changes nothing.
- R9: Reads of unmapped register addresses return 0x00. Writes to them are acknowledged and change nothing.
- R10: Any change of `bus_mode_en` returns register 0x00 to 0x00 and register 0x03 to 0x0F. While `bus_mode_en` is low, `sda_drive` stays 0.
- R11: If SCL stays low for `TIMEOUT_CYC` system clocks, the block returns to idle and releases SDA. It then ignores the bus until a START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_mode_en | input | 1 | Serial-interface mode enable; any edge resets the registers |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level |
| strap_addr | input | 4 | Strapped low four bits of the target address |
| link_ok | input | 4 | Per-input signal-present flags (1 = valid signal) |
| sda_drive | output | 1 | 1 pulls SDA low (open-drain enable) |
| route_cfg | output | 8 | Route register: 2-bit input select per output |
| ctrl_cfg | output | 8 | Control register contents |

## Verification
All 128 seven-bit addresses are tried against a fixed strap value, and one more strap value is checked. This shows that only the one matching address is acknowledged. It also catches a wrong fixed prefix, wrong strap bit order, or a swapped R/W position. Data patterns with alternating, sparse and dense ones are written to and read back from both writable registers. Each 2-bit route field is compared against its arithmetic slice, which exposes shifted or crossed fields. All 16 link-flag patterns are read back, along with writes to the read-only and unmapped addresses, to separate decoding faults from storage faults. Separate runs cover the ignore-until-START behaviour after a foreign address, a mode toggle in both directions, and a clock held low past the timeout during an acknowledge.

// File: rtl/smb_slave_pkg.sv
`timescale 1ns/1ps
package smb_slave_pkg;
    localparam int BYTE_W = 8;
    localparam int BIT_CNT_W = 4;

    localparam logic [BYTE_W-1:0] REG_ROUTE = 8'h00;
    localparam logic [BYTE_W-1:0] REG_CTRL  = 8'h03;
    localparam logic [BYTE_W-1:0] REG_LINK  = 8'h04;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_ADDR,
        PH_ADDR_ACK,
        PH_PTR,
        PH_PTR_ACK,
        PH_WDATA,
        PH_WDATA_ACK,
        PH_TX,
        PH_TX_ACK,
        PH_IGNORE
    } phase_e;
endpackage

// File: rtl/smb_line_sync.sv
`timescale 1ns/1ps
module smb_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    localparam int PIPE_W = SYNC_STAGES + 1;

    logic [PIPE_W-1:0] scl_pipe_d, scl_pipe_q;
    logic [PIPE_W-1:0] sda_pipe_d, sda_pipe_q;

    always_comb begin
        scl_pipe_d = {scl_pipe_q[PIPE_W-2:0], scl_in};
        sda_pipe_d = {sda_pipe_q[PIPE_W-2:0], sda_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe_q <= '1;
            sda_pipe_q <= '1;
        end else begin
            scl_pipe_q <= scl_pipe_d;
            sda_pipe_q <= sda_pipe_d;
        end
    end

    logic scl_prev, sda_prev;
    assign scl_lvl  = scl_pipe_q[PIPE_W-2];
    assign sda_lvl  = sda_pipe_q[PIPE_W-2];
    assign scl_prev = scl_pipe_q[PIPE_W-1];
    assign sda_prev = sda_pipe_q[PIPE_W-1];

    assign scl_rise  = scl_lvl & ~scl_prev;
    assign scl_fall  = ~scl_lvl & scl_prev;
    assign start_evt = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
    assign stop_evt  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/smb_regbank.sv
`timescale 1ns/1ps
module smb_regbank
    import smb_slave_pkg::*;
#(
    parameter int N_OUT = 4,
    localparam int SEL_W = $clog2(N_OUT),
    localparam int ROUTE_W = N_OUT * SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [BYTE_W-1:0] rd_addr,
    input  logic [N_OUT-1:0]  link_ok,
    output logic [ROUTE_W-1:0] route_q,
    output logic [BYTE_W-1:0] ctrl_q,
    output logic [BYTE_W-1:0] rd_data
);
    localparam logic [BYTE_W-1:0] CTRL_DEF = BYTE_W'((1 << N_OUT) - 1);

    typedef struct packed {
        logic [ROUTE_W-1:0] route;
        logic [BYTE_W-1:0]  ctrl;
    } bank_t;

    bank_t b_d, b_q;

    always_comb begin
        b_d = b_q;
        if (clear) begin
            b_d.route = '0;
            b_d.ctrl  = CTRL_DEF;
        end else if (wr_en) begin
            if (wr_addr == REG_ROUTE) b_d.route = wr_data[ROUTE_W-1:0];
            if (wr_addr == REG_CTRL)  b_d.ctrl  = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_q.route <= '0;
            b_q.ctrl  <= CTRL_DEF;
        end else begin
            b_q <= b_d;
        end
    end

    logic [BYTE_W-1:0] link_byte, route_byte;
    for (genvar i = 0; i < BYTE_W; i++) begin : g_pad
        if (i < N_OUT) begin : g_link
            assign link_byte[i] = link_ok[i];
        end else begin : g_link_rsvd
            assign link_byte[i] = 1'b0;
        end
        if (i < ROUTE_W) begin : g_route
            assign route_byte[i] = b_q.route[i];
        end else begin : g_route_rsvd
            assign route_byte[i] = 1'b0;
        end
    end

    always_comb begin
        unique case (rd_addr)
            REG_ROUTE: rd_data = route_byte;
            REG_CTRL:  rd_data = b_q.ctrl;
            REG_LINK:  rd_data = link_byte;
            default:   rd_data = '0;
        endcase
    end

    assign route_q = b_q.route;
    assign ctrl_q  = b_q.ctrl;
endmodule

// File: rtl/smb_reg_slave.sv
`timescale 1ns/1ps
module smb_reg_slave
    import smb_slave_pkg::*;
#(
    parameter int          N_OUT       = 4,
    parameter logic [2:0]  FIXED_HI    = 3'b101,
    parameter int          TIMEOUT_CYC = 6_000_000,
    parameter int          SYNC_STAGES = 2,
    localparam int         ROUTE_W     = N_OUT * $clog2(N_OUT)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_mode_en,
    input  logic               scl_in,
    input  logic               sda_in,
    input  logic [3:0]         strap_addr,
    input  logic [N_OUT-1:0]   link_ok,
    output logic               sda_drive,
    output logic [ROUTE_W-1:0] route_cfg,
    output logic [BYTE_W-1:0]  ctrl_cfg
);
    localparam int TO_W = $clog2(TIMEOUT_CYC + 1);
    localparam logic [TO_W-1:0] TO_LAST = TO_W'(TIMEOUT_CYC - 1);

    typedef struct packed {
        phase_e                 phase;
        logic [BYTE_W-1:0]      shreg;
        logic [BIT_CNT_W-1:0]   bit_cnt;
        logic [BYTE_W-1:0]      ptr;
        logic                   rd_dir;
        logic                   host_nack;
        logic [TO_W-1:0]        low_cnt;
        logic                   mode;
    } slave_t;

    slave_t s_d, s_q;

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;
    logic wr_en, clear;
    logic [BYTE_W-1:0] rd_data;
    logic addr_hit;
    logic mode_seen;

    smb_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    smb_regbank #(.N_OUT(N_OUT)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .wr_en   (wr_en),
        .wr_addr (s_q.ptr),
        .wr_data (s_q.shreg),
        .rd_addr (s_q.ptr),
        .link_ok (link_ok),
        .route_q (route_cfg),
        .ctrl_q  (ctrl_cfg),
        .rd_data (rd_data)
    );

    assign addr_hit  = (s_q.shreg[BYTE_W-1:1] == {FIXED_HI, strap_addr});
    assign clear     = (bus_mode_en != s_q.mode);
    assign mode_seen = s_q.mode;

    always_comb begin
        s_d      = s_q;
        wr_en    = 1'b0;
        s_d.mode = bus_mode_en;

        unique case (s_q.phase)
            PH_ADDR, PH_PTR, PH_WDATA: begin
                if (scl_rise) begin
                    s_d.shreg   = {s_q.shreg[BYTE_W-2:0], sda_lvl};
                    s_d.bit_cnt = s_q.bit_cnt + 1'b1;
                end else if (scl_fall && s_q.bit_cnt == BIT_CNT_W'(BYTE_W)) begin
                    s_d.bit_cnt = '0;
                    if (s_q.phase == PH_ADDR) begin
                        if (addr_hit) begin
                            s_d.rd_dir = s_q.shreg[0];
                            s_d.phase  = PH_ADDR_ACK;
                        end else begin
                            s_d.phase  = PH_IGNORE;
                        end
                    end else if (s_q.phase == PH_PTR) begin
                        s_d.ptr   = s_q.shreg;
                        s_d.phase = PH_PTR_ACK;
                    end else begin
                        wr_en     = 1'b1;
                        s_d.phase = PH_WDATA_ACK;
                    end
                end
            end
            PH_ADDR_ACK: begin
                if (scl_fall) begin
                    s_d.bit_cnt = '0;
                    if (s_q.rd_dir) begin
                        s_d.shreg = rd_data;
                        s_d.phase = PH_TX;
                    end else begin
                        s_d.phase = PH_PTR;
                    end
                end
            end
            PH_PTR_ACK: begin
                if (scl_fall) s_d.phase = PH_WDATA;
            end
            PH_WDATA_ACK: begin
                if (scl_fall) s_d.phase = PH_IGNORE;
            end
            PH_TX: begin
                if (scl_fall) begin
                    s_d.shreg   = {s_q.shreg[BYTE_W-2:0], 1'b0};
                    s_d.bit_cnt = s_q.bit_cnt + 1'b1;
                    if (s_q.bit_cnt == BIT_CNT_W'(BYTE_W - 1)) begin
                        s_d.bit_cnt = '0;
                        s_d.phase   = PH_TX_ACK;
                    end
                end
            end
            PH_TX_ACK: begin
                if (scl_rise) s_d.host_nack = sda_lvl;
                if (scl_fall) begin
                    if (s_q.host_nack) begin
                        s_d.phase = PH_IGNORE;
                    end else begin
                        s_d.shreg = rd_data;
                        s_d.phase = PH_TX;
                    end
                end
            end
            default: ;
        endcase

        if (start_evt) begin
            s_d.phase   = PH_ADDR;
            s_d.bit_cnt = '0;
        end else if (stop_evt) begin
            s_d.phase = PH_IDLE;
        end

        if (!scl_lvl && s_q.phase != PH_IDLE) begin
            if (s_q.low_cnt == TO_LAST) begin
                s_d.low_cnt = '0;
                s_d.phase   = PH_IDLE;
            end else begin
                s_d.low_cnt = s_q.low_cnt + 1'b1;
            end
        end else begin
            s_d.low_cnt = '0;
        end

        if (!bus_mode_en) begin
            s_d.phase   = PH_IDLE;
            s_d.bit_cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.phase     <= PH_IDLE;
            s_q.shreg     <= '0;
            s_q.bit_cnt   <= '0;
            s_q.ptr       <= '0;
            s_q.rd_dir    <= 1'b0;
            s_q.host_nack <= 1'b1;
            s_q.low_cnt   <= '0;
            s_q.mode      <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        unique case (s_q.phase)
            PH_ADDR_ACK, PH_PTR_ACK, PH_WDATA_ACK: sda_drive = 1'b1;
            PH_TX:                                 sda_drive = ~s_q.shreg[BYTE_W-1];
            default:                               sda_drive = 1'b0;
        endcase
    end
endmodule

// File: rtl/smb_reg_slave_chk.sv
`timescale 1ns/1ps
module smb_reg_slave_chk #(
    parameter int N_OUT       = 4,
    parameter int TIMEOUT_CYC = 6_000_000,
    parameter int ROUTE_W     = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_mode_en,
    input logic               mode_seen,
    input logic               scl_lvl,
    input logic               sda_drive,
    input logic               wr_en,
    input logic [ROUTE_W-1:0] route_cfg,
    input logic [7:0]         ctrl_cfg
);
    localparam logic [7:0] CTRL_DEF = 8'((1 << N_OUT) - 1);
    localparam int RUN_W = $clog2(TIMEOUT_CYC + 8);
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(TIMEOUT_CYC + 4);

    logic [RUN_W-1:0] low_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              low_run_q <= '0;
        else if (scl_lvl)        low_run_q <= '0;
        else if (low_run_q != RUN_MAX) low_run_q <= low_run_q + 1'b1;
    end

    assert_mode_off_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_mode_en |=> !sda_drive);

    assert_toggle_defaults_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_mode_en != mode_seen) |=> (route_cfg == '0 && ctrl_cfg == CTRL_DEF));

    assert_drive_on_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_drive) |-> !$past(scl_lvl));

    assert_timeout_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (low_run_q > RUN_W'(TIMEOUT_CYC + 2)) |-> !sda_drive);

    assert_cfg_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && bus_mode_en == mode_seen) |=> ($stable(route_cfg) && $stable(ctrl_cfg)));
endmodule

bind smb_reg_slave smb_reg_slave_chk #(
    .N_OUT       (N_OUT),
    .TIMEOUT_CYC (TIMEOUT_CYC),
    .ROUTE_W     (ROUTE_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_mode_en (bus_mode_en),
    .mode_seen   (mode_seen),
    .scl_lvl     (scl_lvl),
    .sda_drive   (sda_drive),
    .wr_en       (wr_en),
    .route_cfg   (route_cfg),
    .ctrl_cfg    (ctrl_cfg)
);

// File: tb/tb_smb_reg_slave.sv
`timescale 1ns/1ps
module tb_smb_reg_slave;
    localparam int TO = 400;
    localparam int Q  = 6;
    localparam int H  = 12;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst_n, mode, host_scl, host_sda;
    logic [3:0] strap, link;
    logic       sda_drive;
    logic [7:0] route, ctrl;
    wire        sda_line = host_sda & ~sda_drive;

    smb_reg_slave #(.TIMEOUT_CYC(TO)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_mode_en (mode),
        .scl_in      (host_scl),
        .sda_in      (sda_line),
        .strap_addr  (strap),
        .link_ok     (link),
        .sda_drive   (sda_drive),
        .route_cfg   (route),
        .ctrl_cfg    (ctrl)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    task automatic wclk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    task automatic bus_start();
        host_sda = 1'b1; wclk(Q);
        host_scl = 1'b1; wclk(Q);
        host_sda = 1'b0; wclk(Q);
        host_scl = 1'b0; wclk(Q);
    endtask

    task automatic bus_stop();
        host_sda = 1'b0; wclk(Q);
        host_scl = 1'b1; wclk(Q);
        host_sda = 1'b1; wclk(Q);
    endtask

    task automatic send_bits(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            host_sda = b[i]; wclk(Q);
            host_scl = 1'b1; wclk(H);
            host_scl = 1'b0; wclk(Q);
        end
        host_sda = 1'b1;
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        send_bits(b);
        wclk(Q);
        host_scl = 1'b1; wclk(H / 2);
        ack = ~sda_line;
        wclk(H / 2);
        host_scl = 1'b0; wclk(Q);
    endtask

    task automatic recv_byte(output logic [7:0] d);
        host_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wclk(Q);
            host_scl = 1'b1; wclk(H / 2);
            d[i] = sda_line;
            wclk(H / 2);
            host_scl = 1'b0; wclk(Q);
        end
        host_sda = 1'b1; wclk(Q);
        host_scl = 1'b1; wclk(H);
        host_scl = 1'b0; wclk(Q);
    endtask

    function automatic logic [7:0] own_w();
        return {3'b101, strap, 1'b0};
    endfunction

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] d, output bit ok);
        bit k0, k1, k2;
        bus_start();
        send_byte(own_w(), k0);
        send_byte(a, k1);
        send_byte(d, k2);
        bus_stop();
        ok = k0 & k1 & k2;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [7:0] d, output bit ok);
        bit k0, k1, k2;
        bus_start();
        send_byte(own_w(), k0);
        send_byte(a, k1);
        bus_start();
        send_byte(own_w() | 8'h01, k2);
        recv_byte(d);
        bus_stop();
        ok = k0 & k1 & k2;
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        bit ok, ack;
        logic [7:0] pats [8];
        pats = '{8'h00, 8'hFF, 8'h55, 8'hAA, 8'h1B, 8'hE4, 8'h80, 8'h01};

        rst_n = 1'b0; mode = 1'b1; host_scl = 1'b1; host_sda = 1'b1;
        strap = 4'b1001; link = 4'b0000;
        wclk(5);
        rst_n = 1'b1;
        wclk(5);

        // Reset state: R6 R7
        check(route == 8'h00, "R6 route reset", route, 8'h00);
        check(ctrl == 8'h0F, "R7 ctrl reset", ctrl, 8'h0F);
        check(sda_drive == 1'b0, "R2 idle no drive", sda_drive, 0);

        // R1: sweep all 7-bit addresses
        for (int a = 0; a < 128; a++) begin
            bus_start();
            send_byte(8'(a << 1), ack);
            bus_stop();
            check(ack == (a == {3'b101, strap}), "R1 address sweep", {a, 23'h0, ack}, {a, 23'h0, (a == {3'b101, strap})});
        end
        strap = 4'b0110;
        wclk(4);
        bus_start(); send_byte(8'hAC, ack); bus_stop();
        check(ack, "R1 second strap match", ack, 1);
        bus_start(); send_byte(8'hB2, ack); bus_stop();
        check(!ack, "R1 old strap rejected", ack, 0);
        strap = 4'b1001;
        wclk(4);

        // R1: foreign address, then bus ignored until START
        bus_start();
        send_byte(8'h30, ack);
        check(!ack, "R1 foreign nack", ack, 0);
        send_byte(8'hB2, ack);
        check(!ack, "R1 ignored own address w/o START", ack, 0);
        send_byte(8'h00, ack);
        send_byte(8'h77, ack);
        check(!ack, "R1 ignored data", ack, 0);
        bus_stop();
        check(route == 8'h00, "R1 ignored write no effect", route, 0);

        // R4 R5 R6: route register patterns
        foreach (pats[i]) begin
            wr_reg(8'h00, pats[i], ok);
            check(ok, "R3 write acks", ok, 1);
            check(route == pats[i], "R4 route written", route, pats[i]);
            for (int k = 0; k < 4; k++)
                check(route[2*k +: 2] == 2'((pats[i] >> (2*k)) & 3), "R6 select field", route[2*k +: 2], (pats[i] >> (2*k)) & 3);
            rd_reg(8'h00, rd, ok);
            check(ok && rd == pats[i], "R5 route readback", rd, pats[i]);
        end

        // R7: control register
        for (int i = 0; i < 5; i++) begin
            wr_reg(8'h03, pats[i+1] ^ 8'h30, ok);
            check(ctrl == (pats[i+1] ^ 8'h30), "R7 ctrl written", ctrl, pats[i+1] ^ 8'h30);
            rd_reg(8'h03, rd, ok);
            check(ok && rd == (pats[i+1] ^ 8'h30), "R7 ctrl readback", rd, pats[i+1] ^ 8'h30);
        end

        // R8: link register, all patterns
        for (int p = 0; p < 16; p++) begin
            link = 4'(p);
            rd_reg(8'h04, rd, ok);
            check(ok && rd == 8'(p), "R8 link readback", rd, p);
        end
        wr_reg(8'h00, 8'h96, ok);
        wr_reg(8'h03, 8'h4C, ok);
        link = 4'b1010;
        wr_reg(8'h04, 8'hFF, ok);
        check(ok, "R8 write to read-only acked", ok, 1);
        rd_reg(8'h04, rd, ok);
        check(rd == 8'h0A, "R8 read-only unchanged", rd, 8'h0A);
        check(route == 8'h96 && ctrl == 8'h4C, "R8 other regs unchanged", {route, ctrl}, 16'h964C);

        // R9: unmapped addresses
        begin
            logic [7:0] un [5];
            un = '{8'h01, 8'h02, 8'h05, 8'h80, 8'hFF};
            foreach (un[i]) begin
                wr_reg(un[i], 8'hA5, ok);
                check(ok, "R9 unmapped write acked", ok, 1);
                rd_reg(un[i], rd, ok);
                check(ok && rd == 8'h00, "R9 unmapped read zero", rd, 0);
            end
            check(route == 8'h96 && ctrl == 8'h4C, "R9 unmapped write no effect", {route, ctrl}, 16'h964C);
        end

        // R10: mode toggles
        mode = 1'b0; wclk(4);
        check(route == 8'h00 && ctrl == 8'h0F, "R10 fall resets regs", {route, ctrl}, 16'h000F);
        bus_start(); send_byte(own_w(), ack); bus_stop();
        check(!ack, "R10 mode low no ack", ack, 0);
        mode = 1'b1; wclk(4);
        wr_reg(8'h00, 8'hC3, ok);
        check(route == 8'hC3, "R10 write after re-enable", route, 8'hC3);
        mode = 1'b0; wclk(2); mode = 1'b1; wclk(4);
        check(route == 8'h00 && ctrl == 8'h0F, "R10 pulse resets regs", {route, ctrl}, 16'h000F);

        // R11: SCL held low during ACK
        bus_start();
        send_bits(own_w());
        wclk(Q);
        check(sda_drive == 1'b1, "R3 ack driven while low", sda_drive, 1);
        wclk(TO / 2);
        check(sda_drive == 1'b1, "R11 before timeout still held", sda_drive, 1);
        wclk(TO / 2 + 20);
        check(sda_drive == 1'b0, "R11 released after timeout", sda_drive, 0);
        host_scl = 1'b1; wclk(H); host_scl = 1'b0; wclk(Q);
        send_byte(8'h00, ack);
        check(!ack, "R11 idle after timeout", ack, 0);
        bus_stop();
        wr_reg(8'h00, 8'h39, ok);
        check(ok && route == 8'h39, "R11 recovers on START", route, 8'h39);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule